// File: doc/BRIEF.md
# Conditional Jump Evaluation Unit

This unit belongs to a list-sequencing engine that runs a stored program of bus commands. When the fetch logic presents an instruction word, the unit works out whether it is a jump. If it is, the unit decides from its three-bit condition code whether the jump is taken. It then produces the address of the next instruction and the side strobes that the rest of the engine acts on. Those strobes restore the write-data pointer to its last host-loaded value, request a wait for the next trigger (which also drops the running flag), and hold both data pointers still.

The conditions use the Q result of the last bus cycle and the data from the most recent read cycle. The read data is compared, unsigned, against a host-loaded comparator value. Evaluation is done by a small state machine:

- `ST_IDLE`: waits for `eval_req_i` and captures all operands. The transition `ST_IDLE -> ST_DECODE` happens on an accepted request. With no request the unit stays in `ST_IDLE`.
- `ST_DECODE`: registers the decoded fields and the comparison flags. The transition is `ST_DECODE -> ST_RESOLVE`.
- `ST_RESOLVE`: registers the decision, the next address and the strobes. The transition is `ST_RESOLVE -> ST_DONE`.
- `ST_DONE`: presents the result for one cycle. The transition is `ST_DONE -> ST_IDLE`.

Top module: `jump_eval`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `done_o`, `busy_o`, `taken_o`, `restore_wp_o`, `await_trig_o`, `is_jump_o` and `hold_ptrs_o` are 0, and `next_ip_o` is 0.
- R2: A request sampled high in `ST_IDLE` on clock edge k gives `done_o` high for exactly one cycle, after edge k+2. `busy_o` is high from edge k until `done_o` falls. `taken_o`, `restore_wp_o` and `await_trig_o` are 0 whenever `done_o` is 0. Requests that arrive while `busy_o` is high are ignored.
- R3: The word is a jump when bits [15] and [14] are both 1. The condition code is bits [13:11] and the target address is bits [10:0]. Code 000 always takes the jump. A taken jump sets `next_ip_o` to the target, zero-extended to 13 bits.
- R4: Code 001 and code 101 take the jump only when `last_q_i` was 0 at capture.
- R5: Code 010 takes the jump when the read data is greater than the comparator value. Code 011 takes it when the read data is less. Both comparisons are unsigned over 24 bits.
- R6: Code 110 takes the jump when the read data equals the comparator value.
- R7: A jump that is not taken gives `next_ip_o` = current pointer + 1, modulo 2^13. It keeps `hold_ptrs_o` high and raises neither `restore_wp_o` nor `await_trig_o`.
- R8: `await_trig_o` is high in the done cycle only for a taken jump with code 100 or 101.
- R9: `restore_wp_o` is high in the done cycle only for code 111, which always takes the jump.
- R10: A word that is not a jump gives `is_jump_o`=0, `taken_o`=0, `hold_ptrs_o`=0 and `next_ip_o` = current pointer + 1. Every jump word gives `hold_ptrs_o`=1.
- R11: The result depends only on the operands captured on the accepting edge. Changes to the inputs after that edge have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| eval_req_i | input | 1 | Start evaluation of the presented word |
| instr_i | input | 16 | Instruction word |
| last_q_i | input | 1 | Q result of the last bus cycle |
| rd_data_i | input | 24 | Data of the most recent read cycle |
| cmp_val_i | input | 24 | Host-loaded comparator value |
| cur_ip_i | input | 13 | Current instruction pointer |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | Result valid (one-cycle pulse) |
| is_jump_o | output | 1 | Evaluated word was a jump |
| taken_o | output | 1 | Jump taken (done cycle only) |
| next_ip_o | output | 13 | Next instruction address |
| hold_ptrs_o | output | 1 | Data pointers must not advance |
| restore_wp_o | output | 1 | Restore write pointer strobe (done cycle only) |
| await_trig_o | output | 1 | Stop running and wait for trigger (done cycle only) |

## Verification
The assertions assume that the requester never depends on a request made while `busy_o` is high, and that reset is held for at least one edge before any request. The bench keeps to this: it raises `eval_req_i` only from idle, except for the one directed case that tests whether a request during evaluation is ignored. The stimulus covers all eight condition codes, including compares at the sign-bit boundary, equal values and pointer wrap. It also covers both kinds of non-jump word, and operands that change straight after acceptance.

// File: rtl/jump_eval_pkg.sv
package jump_eval_pkg;

    typedef enum logic [2:0] {
        JC_ALWAYS      = 3'd0,
        JC_NOQ         = 3'd1,
        JC_GT          = 3'd2,
        JC_LT          = 3'd3,
        JC_ALWAYS_WAIT = 3'd4,
        JC_NOQ_WAIT    = 3'd5,
        JC_EQ          = 3'd6,
        JC_RESTORE     = 3'd7
    } cond_e;

    typedef struct packed {
        logic no_q;
        logic gt;
        logic lt;
        logic eq;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DECODE  = 2'd1,
        ST_RESOLVE = 2'd2,
        ST_DONE    = 2'd3
    } state_e;

endpackage

// File: rtl/jump_eval_decode.sv
module jump_eval_decode
    import jump_eval_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int ADDR_W  = 11
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic               is_jump_o,
    output cond_e              cond_o,
    output logic [ADDR_W-1:0]  dest_o
);
    localparam int TAG_HI  = INSTR_W - 1;
    localparam int TAG_LO  = INSTR_W - 2;
    localparam int CODE_HI = INSTR_W - 3;

    always_comb begin
        is_jump_o = instr_i[TAG_HI] & instr_i[TAG_LO];
        cond_o    = cond_e'(instr_i[CODE_HI -: 3]);
        dest_o    = instr_i[ADDR_W-1:0];
    end
endmodule

// File: rtl/jump_eval_cmp.sv
module jump_eval_cmp
    import jump_eval_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [DATA_W-1:0] cmp_val_i,
    input  logic              last_q_i,
    output flags_t            flags_o
);
    always_comb begin
        flags_o.no_q = ~last_q_i;
        flags_o.gt   = rd_data_i >  cmp_val_i;
        flags_o.lt   = rd_data_i <  cmp_val_i;
        flags_o.eq   = rd_data_i == cmp_val_i;
    end
endmodule

// File: rtl/jump_eval_target.sv
module jump_eval_target
    import jump_eval_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int IP_W   = 13
) (
    input  logic              is_jump_i,
    input  cond_e             cond_i,
    input  flags_t            flags_i,
    input  logic [ADDR_W-1:0] dest_i,
    input  logic [IP_W-1:0]   cur_ip_i,
    output logic              taken_o,
    output logic [IP_W-1:0]   next_ip_o,
    output logic              restore_o,
    output logic              await_o
);
    logic cond_met;
    logic waits;

    always_comb begin
        waits = 1'b0;
        unique case (cond_i)
            JC_ALWAYS:      cond_met = 1'b1;
            JC_NOQ:         cond_met = flags_i.no_q;
            JC_GT:          cond_met = flags_i.gt;
            JC_LT:          cond_met = flags_i.lt;
            JC_ALWAYS_WAIT: begin cond_met = 1'b1;         waits = 1'b1; end
            JC_NOQ_WAIT:    begin cond_met = flags_i.no_q; waits = 1'b1; end
            JC_EQ:          cond_met = flags_i.eq;
            JC_RESTORE:     cond_met = 1'b1;
            default:        cond_met = 1'b0;
        endcase
        taken_o   = is_jump_i & cond_met;
        next_ip_o = taken_o ? IP_W'(dest_i) : cur_ip_i + IP_W'(1);
        restore_o = taken_o & (cond_i == JC_RESTORE);
        await_o   = taken_o & waits;
    end
endmodule

// File: rtl/jump_eval.sv
module jump_eval
    import jump_eval_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int ADDR_W  = 11,
    parameter int IP_W    = 13,
    parameter int DATA_W  = 24
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               eval_req_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               last_q_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    input  logic [DATA_W-1:0]  cmp_val_i,
    input  logic [IP_W-1:0]    cur_ip_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               is_jump_o,
    output logic               taken_o,
    output logic [IP_W-1:0]    next_ip_o,
    output logic               hold_ptrs_o,
    output logic               restore_wp_o,
    output logic               await_trig_o
);
    state_e state_q, state_d;

    // operands captured on acceptance
    logic [INSTR_W-1:0] instr_q;
    logic               q_q;
    logic [DATA_W-1:0]  rd_q;
    logic [DATA_W-1:0]  cmp_q;
    logic [IP_W-1:0]    ip_q;

    // decode stage
    logic               dec_jump;
    cond_e              dec_cond;
    logic [ADDR_W-1:0]  dec_dest;
    flags_t             cmp_flags;
    logic               jump_q;
    cond_e              cond_q;
    logic [ADDR_W-1:0]  dest_q;
    flags_t             flags_q;

    // resolve stage
    logic               tgt_taken, tgt_restore, tgt_await;
    logic [IP_W-1:0]    tgt_next;
    logic               res_jump, res_taken, res_restore, res_await;
    logic [IP_W-1:0]    res_next;

    jump_eval_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_dec (
        .instr_i   (instr_q),
        .is_jump_o (dec_jump),
        .cond_o    (dec_cond),
        .dest_o    (dec_dest)
    );

    jump_eval_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rd_data_i (rd_q),
        .cmp_val_i (cmp_q),
        .last_q_i  (q_q),
        .flags_o   (cmp_flags)
    );

    jump_eval_target #(.ADDR_W(ADDR_W), .IP_W(IP_W)) u_tgt (
        .is_jump_i (jump_q),
        .cond_i    (cond_q),
        .flags_i   (flags_q),
        .dest_i    (dest_q),
        .cur_ip_i  (ip_q),
        .taken_o   (tgt_taken),
        .next_ip_o (tgt_next),
        .restore_o (tgt_restore),
        .await_o   (tgt_await)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (eval_req_i) state_d = ST_DECODE;
            ST_DECODE:  state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and per-state datapath capture
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            instr_q     <= '0;
            q_q         <= 1'b0;
            rd_q        <= '0;
            cmp_q       <= '0;
            ip_q        <= '0;
            jump_q      <= 1'b0;
            cond_q      <= JC_ALWAYS;
            dest_q      <= '0;
            flags_q     <= '0;
            res_jump    <= 1'b0;
            res_taken   <= 1'b0;
            res_restore <= 1'b0;
            res_await   <= 1'b0;
            res_next    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (eval_req_i) begin
                    instr_q <= instr_i;
                    q_q     <= last_q_i;
                    rd_q    <= rd_data_i;
                    cmp_q   <= cmp_val_i;
                    ip_q    <= cur_ip_i;
                end
                ST_DECODE: begin
                    jump_q  <= dec_jump;
                    cond_q  <= dec_cond;
                    dest_q  <= dec_dest;
                    flags_q <= cmp_flags;
                end
                ST_RESOLVE: begin
                    res_jump    <= jump_q;
                    res_taken   <= tgt_taken;
                    res_restore <= tgt_restore;
                    res_await   <= tgt_await;
                    res_next    <= tgt_next;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done_o       = (state_q == ST_DONE);
        busy_o       = (state_q != ST_IDLE);
        is_jump_o    = res_jump;
        hold_ptrs_o  = res_jump;
        next_ip_o    = res_next;
        taken_o      = done_o & res_taken;
        restore_wp_o = done_o & res_restore;
        await_trig_o = done_o & res_await;
    end
endmodule

// File: rtl/jump_eval_chk.sv
module jump_eval_chk #(
    parameter int IP_W = 13
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            busy_o,
    input logic            done_o,
    input logic            is_jump_o,
    input logic            taken_o,
    input logic [IP_W-1:0] next_ip_o,
    input logic            hold_ptrs_o,
    input logic            restore_wp_o,
    input logic            await_trig_o
);
    // R2
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R2
    done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (busy_o && $past(busy_o)));
    // R2
    strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> !(taken_o || restore_wp_o || await_trig_o));
    // R8
    await_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        await_trig_o |-> (taken_o && is_jump_o));
    // R9
    restore_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restore_wp_o |-> (taken_o && !await_trig_o));
    // R7
    not_taken_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && is_jump_o && !taken_o) |-> (hold_ptrs_o && !restore_wp_o && !await_trig_o));
    // R10
    plain_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !is_jump_o) |-> (!taken_o && !hold_ptrs_o));
    // R2
    result_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && $past(!busy_o)) |-> $stable(next_ip_o));
endmodule

bind jump_eval jump_eval_chk #(.IP_W(IP_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .is_jump_o    (is_jump_o),
    .taken_o      (taken_o),
    .next_ip_o    (next_ip_o),
    .hold_ptrs_o  (hold_ptrs_o),
    .restore_wp_o (restore_wp_o),
    .await_trig_o (await_trig_o)
);

// File: tb/jump_eval_tb_top.sv
module jump_eval_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic [15:0] instr;
        logic        q;
        logic [23:0] rd;
        logic [23:0] cmp;
        logic [12:0] ip;
        logic        tk;
        logic [12:0] nx;
        logic        rs;
        logic        aw;
        logic        jmp;
    } vec_t;

    // bits [15:14]=11 jump tag, [13:11] code, [10:0] target
    localparam vec_t VECS [NV] = '{
        '{{2'b11,3'd0,11'h7FF}, 1'b1, 24'h0,      24'h0,      13'h0100, 1'b1, 13'h07FF, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd1,11'h010}, 1'b0, 24'h0,      24'h0,      13'h0200, 1'b1, 13'h0010, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd1,11'h010}, 1'b1, 24'h0,      24'h0,      13'h0200, 1'b0, 13'h0201, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd2,11'h020}, 1'b1, 24'h800000, 24'h7FFFFF, 13'h0300, 1'b1, 13'h0020, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd2,11'h020}, 1'b1, 24'h000123, 24'h000123, 13'h0300, 1'b0, 13'h0301, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd3,11'h030}, 1'b1, 24'h000001, 24'hFFFFFF, 13'h0400, 1'b1, 13'h0030, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd3,11'h030}, 1'b1, 24'hFFFFFF, 24'h000001, 13'h0400, 1'b0, 13'h0401, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd6,11'h040}, 1'b1, 24'h00ABCD, 24'h00ABCD, 13'h0500, 1'b1, 13'h0040, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd6,11'h040}, 1'b1, 24'h00ABCC, 24'h00ABCD, 13'h0500, 1'b0, 13'h0501, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd4,11'h050}, 1'b1, 24'h0,      24'h0,      13'h0600, 1'b1, 13'h0050, 1'b0, 1'b1, 1'b1},
        '{{2'b11,3'd5,11'h060}, 1'b0, 24'h0,      24'h0,      13'h0700, 1'b1, 13'h0060, 1'b0, 1'b1, 1'b1},
        '{{2'b11,3'd5,11'h060}, 1'b1, 24'h0,      24'h0,      13'h1FFF, 1'b0, 13'h0000, 1'b0, 1'b0, 1'b1},
        '{{2'b11,3'd7,11'h070}, 1'b1, 24'h0,      24'h0,      13'h0800, 1'b1, 13'h0070, 1'b1, 1'b0, 1'b1},
        '{16'h8000,             1'b1, 24'h0,      24'h0,      13'h0005, 1'b0, 13'h0006, 1'b0, 1'b0, 1'b0},
        '{16'h4123,             1'b0, 24'h0,      24'h0,      13'h0009, 1'b0, 13'h000A, 1'b0, 1'b0, 1'b0}
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        eval_req_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic        last_q_i = 1'b0;
    logic [23:0] rd_data_i = '0;
    logic [23:0] cmp_val_i = '0;
    logic [12:0] cur_ip_i = '0;
    logic        busy_o, done_o, is_jump_o, taken_o, hold_ptrs_o, restore_wp_o, await_trig_o;
    logic [12:0] next_ip_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    jump_eval dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .eval_req_i(eval_req_i), .instr_i(instr_i),
        .last_q_i(last_q_i), .rd_data_i(rd_data_i), .cmp_val_i(cmp_val_i), .cur_ip_i(cur_ip_i),
        .busy_o(busy_o), .done_o(done_o), .is_jump_o(is_jump_o), .taken_o(taken_o),
        .next_ip_o(next_ip_o), .hold_ptrs_o(hold_ptrs_o), .restore_wp_o(restore_wp_o),
        .await_trig_o(await_trig_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (!v.jmp) return "R10";
        case (v.instr[13:11])
            3'd0:       return "R3";
            3'd1:       return "R4";
            3'd2, 3'd3: return "R5";
            3'd4, 3'd5: return "R8";
            3'd6:       return "R6";
            default:    return "R9";
        endcase
    endfunction

    task automatic drive(input vec_t v);
        instr_i = v.instr; last_q_i = v.q; rd_data_i = v.rd;
        cmp_val_i = v.cmp; cur_ip_i = v.ip;
    endtask

    task automatic check_result(input vec_t v, input string t);
        chk(done_o == 1'b1, "R2", "done at third cycle", 32'(done_o), 32'd1);
        chk(taken_o == v.tk, t, "taken", 32'(taken_o), 32'(v.tk));
        chk(next_ip_o == v.nx, t, "next_ip", 32'(next_ip_o), 32'(v.nx));
        chk(restore_wp_o == v.rs, t, "restore_wp", 32'(restore_wp_o), 32'(v.rs));
        chk(await_trig_o == v.aw, t, "await_trig", 32'(await_trig_o), 32'(v.aw));
        chk(is_jump_o == v.jmp, "R10", "is_jump", 32'(is_jump_o), 32'(v.jmp));
        chk(hold_ptrs_o == v.jmp, "R10", "hold_ptrs", 32'(hold_ptrs_o), 32'(v.jmp));
        if (v.jmp && !v.tk)
            chk(hold_ptrs_o && !restore_wp_o && !await_trig_o, "R7", "not-taken quiet",
                32'({hold_ptrs_o, restore_wp_o, await_trig_o}), 32'b100);
    endtask

    task automatic run_vec(input vec_t v, input bit scramble);
        string t;
        t = tag_of(v);
        @(negedge clk_i);
        drive(v);
        eval_req_i = 1'b1;
        @(negedge clk_i);
        eval_req_i = 1'b0;
        if (scramble) begin // R11: operands change after acceptance
            instr_i = 16'h8000; last_q_i = ~v.q; rd_data_i = 24'h0;
            cmp_val_i = 24'hFFFFFF; cur_ip_i = 13'h0AAA;
            t = "R11";
        end
        chk(done_o == 1'b0 && busy_o == 1'b1, "R2", "first cycle after accept",
            32'({done_o, busy_o}), 32'b01);
        @(negedge clk_i);
        chk(done_o == 1'b0, "R2", "second cycle", 32'(done_o), 32'd0);
        @(negedge clk_i);
        check_result(v, t);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: reset state
        chk({done_o, busy_o, taken_o, restore_wp_o, await_trig_o, is_jump_o, hold_ptrs_o} == 7'b0
            && next_ip_o == 13'h0, "R1", "outputs in reset",
            32'({done_o, busy_o, taken_o, restore_wp_o, await_trig_o, is_jump_o, hold_ptrs_o}), 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk({done_o, busy_o, taken_o, is_jump_o, hold_ptrs_o} == 5'b0, "R1", "outputs after release",
            32'({done_o, busy_o, taken_o, is_jump_o, hold_ptrs_o}), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R11: result from captured operands only
        run_vec(VECS[3], 1'b1);

        // R2: request held during evaluation is ignored
        @(negedge clk_i);
        instr_i = {2'b11, 3'd0, 11'h111}; cur_ip_i = 13'h0010; eval_req_i = 1'b1;
        @(negedge clk_i);
        instr_i = {2'b11, 3'd0, 11'h222};
        @(negedge clk_i);
        @(negedge clk_i);
        chk(done_o && next_ip_o == 13'h0111, "R2", "busy request ignored",
            32'(next_ip_o), 32'h111);
        eval_req_i = 1'b0;
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk_i);
                if (done_o) extra++;
            end
            chk(extra == 0, "R2", "no second done", 32'(extra), 32'd0);
        end
        chk(next_ip_o == 13'h0111 && !taken_o, "R2", "result held, strobes low in idle",
            32'(next_ip_o), 32'h111);

        // R1: reset again mid-idle clears result
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk(next_ip_o == 13'h0 && !is_jump_o, "R1", "re-reset clears", 32'(next_ip_o), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule